// File: doc/BRIEF.md
# Floating-Point Register Stack Controller

This block keeps the bookkeeping state of an eight-entry circular floating-point register stack. It does not hold register values and it does no arithmetic. It holds the top-of-stack pointer, one empty flag per physical slot, a 16-bit status word and a 16-bit control word. A sequencer issues at most one command per clock. The commands are push, pop, pointer step up, pointer step down, free slot, initialise, clear exceptions, raise exceptions, load control word, load condition codes and wait. Every command takes effect at the next clock edge.

The status word is read with the live pointer merged into bits 13:11. The summary bit 7 is exported as a pending-exception level. A wait command returns a fault pulse one cycle later when the summary bit is set. Push and pop report the physical slot they touched, so the datapath can write or release that entry. A combinational port converts a stack-relative register number into a physical slot index.

Top module: `fstk_ctrl`

## Requirements
- R1: After reset the pointer is 0, every empty flag is 1 (flag value 1 means empty, 0 means valid), the stored status is 0, the control word is 0x037F, `slot_idx` is 0, and both `wait_fault` and `exc_pending` are low.
- R2: Push (op 1) decrements the pointer modulo 8, clears the empty flag of the new top slot, and sets `slot_idx` to that new top.
- R3: Pop (op 2) sets the empty flag of the current top slot, increments the pointer modulo 8, and sets `slot_idx` to the slot that was released.
- R4: Step up (op 3) and step down (op 4) change the pointer by +1 and -1 modulo 8. Both clear status bits 14, 10, 9 and 8 and leave every empty flag unchanged.
- R5: Free (op 5) sets the empty flag of physical slot (pointer + `cmd_data[2:0]`) mod 8. The pointer does not change.
- R6: `status_word` equals the stored status with bits 13:11 replaced by the pointer.
- R7: Initialise (op 6) restores the R1 state for pointer, flags, status and control, whatever the state was before.
- R8: Raise (op 8) ORs `cmd_data[5:0]` into status bits 5:0. Bit 0 is invalid, 1 denormal, 2 zero-divide, 3 overflow, 4 underflow and 5 precision. If any of status bits 5:0 is then set while the matching control bit 5:0 is 0, bits 7 and 15 are also set.
- R9: Clear exceptions (op 7) keeps stored status bits 14:8 and clears all others.
- R10: Load control (op 9) writes `cmd_data` into the control word.
- R11: Load condition codes (op 11) writes `cmd_data[3]` to status bit 14 and `cmd_data[2:0]` to bits 10:8. `exc_pending` always equals status bit 7. Wait (op 10) drives `wait_fault` high in the next cycle exactly when status bit 7 was set. In every other cycle `wait_fault` is low.
- R12: `phys_idx` equals (pointer + `rel_idx`) mod 8 combinationally.
- R13: With `cmd_valid` low, or with op 0 or ops 12 to 15, no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 4 | Command code |
| cmd_data | input | 16 | Command argument: slot offset, flags, control word or condition codes |
| rel_idx | input | 3 | Stack-relative register number |
| phys_idx | output | 3 | Physical slot for `rel_idx` |
| top_ptr | output | 3 | Current top-of-stack pointer |
| tags | output | 8 | Empty flag per physical slot, 1 = empty |
| status_word | output | 16 | Status with pointer merged in bits 13:11 |
| control_word | output | 16 | Control word |
| exc_pending | output | 1 | Unmasked exception summary |
| slot_idx | output | 3 | Slot touched by the last push or pop |
| wait_fault | output | 1 | Fault pulse following a wait with a pending exception |

## Verification
A wrong pointer shows up in `top_ptr`, in status bits 13:11 and in `phys_idx` in the cycle after the command that corrupted it. A flag that is set or cleared in the wrong place shows up on `tags` at once. It also surfaces later as a wrong `slot_idx` when the stack wraps. The bench drives every pointer value through both wrap directions and frees every offset from more than one pointer. It covers the full product of the 64 mask patterns and the six flags. A summary bit that is wrong shows on `exc_pending` one cycle after the raise and on `wait_fault` one cycle after the next wait.

// File: rtl/fstk_pkg.sv
package fstk_pkg;
  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_PUSH  = 4'd1,
    OP_POP   = 4'd2,
    OP_INC   = 4'd3,
    OP_DEC   = 4'd4,
    OP_FREE  = 4'd5,
    OP_INIT  = 4'd6,
    OP_CLEX  = 4'd7,
    OP_RAISE = 4'd8,
    OP_SETCW = 4'd9,
    OP_WAIT  = 4'd10,
    OP_SETCC = 4'd11
  } op_e;

  localparam int          SW_W       = 16;
  localparam int          FLAG_W     = 6;
  localparam int          SUM_BIT    = 7;
  localparam int          BUSY_BIT   = 15;
  localparam int          PTR_LSB    = 11;
  localparam int          CC3_BIT    = 14;
  localparam int          CC_LO      = 8;
  localparam logic [15:0] CW_INIT    = 16'h037F;
  localparam logic [15:0] CC_MASK    = 16'h4700;
  localparam logic [15:0] CLEX_KEEP  = 16'h7F00;
endpackage

// File: rtl/fstk_ptr.sv
module fstk_ptr #(
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_dn,
  input  logic          step_up,
  input  logic          zero,
  input  logic [PW-1:0] rel_idx,
  output logic [PW-1:0] ptr,
  output logic [PW-1:0] phys_idx
);
  logic [PW-1:0] ptr_q, ptr_d;
  logic          ptr_en;

  always_comb begin
    ptr_en = zero | step_dn | step_up;
    ptr_d  = ptr_q;
    if (zero)         ptr_d = '0;
    else if (step_dn) ptr_d = ptr_q - 1'b1;
    else if (step_up) ptr_d = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign ptr      = ptr_q;
  assign phys_idx = ptr_q + rel_idx;
endmodule

// File: rtl/fstk_tags.sv
module fstk_tags #(
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mark_full,
  input  logic [PW-1:0]    full_idx,
  input  logic             mark_empty,
  input  logic [PW-1:0]    empty_idx,
  input  logic             wipe,
  output logic [DEPTH-1:0] tags
);
  logic [DEPTH-1:0] tag_q, tag_d, tag_en;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_comb begin
      tag_en[g] = wipe | (mark_empty && empty_idx == PW'(g))
                       | (mark_full  && full_idx  == PW'(g));
      if (wipe)                                    tag_d[g] = 1'b1;
      else if (mark_empty && empty_idx == PW'(g))  tag_d[g] = 1'b1;
      else                                         tag_d[g] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         tag_q[g] <= 1'b1;
      else if (tag_en[g]) tag_q[g] <= tag_d[g];
    end
  end

  assign tags = tag_q;
endmodule

// File: rtl/fstk_status.sv
module fstk_status
  import fstk_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              do_init,
  input  logic              do_ccclr,
  input  logic              do_clex,
  input  logic              do_raise,
  input  logic [FLAG_W-1:0] raise_flags,
  input  logic              do_setcw,
  input  logic [SW_W-1:0]   cw_in,
  input  logic              do_setcc,
  input  logic [3:0]        cc_in,
  input  logic [PW-1:0]     ptr,
  output logic [SW_W-1:0]   status_word,
  output logic [SW_W-1:0]   control_word,
  output logic              summary
);
  logic [SW_W-1:0] stat_q, stat_d, ctl_q, ctl_d, raised, cc_bits;
  logic            stat_en, ctl_en, unmask_hit;

  always_comb begin
    raised     = stat_q | {{(SW_W-FLAG_W){1'b0}}, raise_flags};
    unmask_hit = |(raised[FLAG_W-1:0] & ~ctl_q[FLAG_W-1:0]);
    if (unmask_hit) begin
      raised[SUM_BIT]  = 1'b1;
      raised[BUSY_BIT] = 1'b1;
    end
    cc_bits               = '0;
    cc_bits[CC3_BIT]      = cc_in[3];
    cc_bits[CC_LO +: 3]   = cc_in[2:0];
  end

  always_comb begin
    stat_en = do_init | do_ccclr | do_clex | do_raise | do_setcc;
    ctl_en  = do_init | do_setcw;
    stat_d  = stat_q;
    ctl_d   = ctl_q;
    if (do_init) begin
      stat_d = '0;
      ctl_d  = CW_INIT;
    end else if (do_ccclr) stat_d = stat_q & ~CC_MASK;
    else if (do_clex)      stat_d = stat_q & CLEX_KEEP;
    else if (do_raise)     stat_d = raised;
    else if (do_setcw)     ctl_d  = cw_in;
    else if (do_setcc)     stat_d = (stat_q & ~CC_MASK) | cc_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      ctl_q  <= CW_INIT;
    end else begin
      if (stat_en) stat_q <= stat_d;
      if (ctl_en)  ctl_q  <= ctl_d;
    end
  end

  always_comb begin
    status_word                 = stat_q;
    status_word[PTR_LSB +: PW]  = ptr;
  end

  assign control_word = ctl_q;
  assign summary      = stat_q[SUM_BIT];
endmodule

// File: rtl/fstk_ctrl.sv
module fstk_ctrl
  import fstk_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [3:0]       cmd_op,
  input  logic [15:0]      cmd_data,
  input  logic [PW-1:0]    rel_idx,
  output logic [PW-1:0]    phys_idx,
  output logic [PW-1:0]    top_ptr,
  output logic [DEPTH-1:0] tags,
  output logic [15:0]      status_word,
  output logic [15:0]      control_word,
  output logic             exc_pending,
  output logic [PW-1:0]    slot_idx,
  output logic             wait_fault
);
  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic          is_push, is_pop, is_inc, is_dec, is_free, is_init;
  logic          is_clex, is_raise, is_setcw, is_wait, is_setcc;
  logic [PW-1:0] push_slot, free_slot, slot_d;
  logic [PW-1:0] slot_q;
  logic          slot_en, fault_q, fault_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    is_push  = cmd_valid && (cmd_op == OP_PUSH);
    is_pop   = cmd_valid && (cmd_op == OP_POP);
    is_inc   = cmd_valid && (cmd_op == OP_INC);
    is_dec   = cmd_valid && (cmd_op == OP_DEC);
    is_free  = cmd_valid && (cmd_op == OP_FREE);
    is_init  = cmd_valid && (cmd_op == OP_INIT);
    is_clex  = cmd_valid && (cmd_op == OP_CLEX);
    is_raise = cmd_valid && (cmd_op == OP_RAISE);
    is_setcw = cmd_valid && (cmd_op == OP_SETCW);
    is_wait  = cmd_valid && (cmd_op == OP_WAIT);
    is_setcc = cmd_valid && (cmd_op == OP_SETCC);
    push_slot = top_ptr - 1'b1;
    free_slot = top_ptr + cmd_data[PW-1:0];
  end

  fstk_ptr #(.DEPTH(DEPTH)) i_ptr (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .step_dn  (is_push | is_dec),
    .step_up  (is_pop | is_inc),
    .zero     (is_init),
    .rel_idx  (rel_idx),
    .ptr      (top_ptr),
    .phys_idx (phys_idx)
  );

  fstk_tags #(.DEPTH(DEPTH)) i_tags (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .mark_full  (is_push),
    .full_idx   (push_slot),
    .mark_empty (is_pop | is_free),
    .empty_idx  (is_pop ? top_ptr : free_slot),
    .wipe       (is_init),
    .tags       (tags)
  );

  fstk_status #(.DEPTH(DEPTH)) i_stat (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .do_init      (is_init),
    .do_ccclr     (is_inc | is_dec),
    .do_clex      (is_clex),
    .do_raise     (is_raise),
    .raise_flags  (cmd_data[FLAG_W-1:0]),
    .do_setcw     (is_setcw),
    .cw_in        (cmd_data),
    .do_setcc     (is_setcc),
    .cc_in        (cmd_data[3:0]),
    .ptr          (top_ptr),
    .status_word  (status_word),
    .control_word (control_word),
    .summary      (exc_pending)
  );

  always_comb begin
    slot_en = is_push | is_pop;
    slot_d  = is_push ? push_slot : top_ptr;
    fault_d = is_wait & exc_pending;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      slot_q  <= '0;
      fault_q <= 1'b0;
    end else begin
      if (slot_en) slot_q <= slot_d;
      fault_q <= fault_d;
    end
  end

  assign slot_idx   = slot_q;
  assign wait_fault = fault_q;
endmodule

// File: rtl/fstk_ctrl_chk.sv
module fstk_ctrl_chk
  import fstk_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [3:0]       cmd_op,
  input logic [PW-1:0]    cmd_data,
  input logic [PW-1:0]    top_ptr,
  input logic [DEPTH-1:0] tags,
  input logic [15:0]      status_word,
  input logic [15:0]      control_word,
  input logic             exc_pending,
  input logic [PW-1:0]    slot_idx,
  input logic             wait_fault
);
  assert_push_moves_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_PUSH |=>
      top_ptr == PW'($past(top_ptr) - 1'b1) && !tags[top_ptr] && slot_idx == top_ptr);

  assert_pop_releases_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_POP |=>
      top_ptr == PW'($past(top_ptr) + 1'b1) && tags[$past(top_ptr)] && slot_idx == $past(top_ptr));

  assert_free_marks_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_FREE |=>
      tags[PW'($past(top_ptr) + $past(cmd_data))] && $stable(top_ptr));

  assert_ptr_in_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[PTR_LSB +: PW] == top_ptr);

  assert_init_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_INIT |=>
      status_word == 16'h0000 && control_word == CW_INIT && (&tags));

  assert_clex_keeps_cc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_CLEX |=>
      status_word[7:0] == 8'h00 && !status_word[15]
      && status_word[14:8] == $past(status_word[14:8]));

  assert_pending_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
    exc_pending == status_word[SUM_BIT]);

  assert_wait_fault_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_WAIT && status_word[SUM_BIT] |=> wait_fault);

  assert_idle_no_change_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(top_ptr) && $stable(tags) && $stable(status_word)
      && $stable(control_word) && !wait_fault);
endmodule

bind fstk_ctrl fstk_ctrl_chk #(.DEPTH(DEPTH)) i_fstk_ctrl_chk (
  .clk          (clk),
  .rst_n        (rst_int_n),
  .cmd_valid    (cmd_valid),
  .cmd_op       (cmd_op),
  .cmd_data     (cmd_data[PW-1:0]),
  .top_ptr      (top_ptr),
  .tags         (tags),
  .status_word  (status_word),
  .control_word (control_word),
  .exc_pending  (exc_pending),
  .slot_idx     (slot_idx),
  .wait_fault   (wait_fault)
);

// File: tb/test_fstk_ctrl.sv
`timescale 1ns/1ps
module test_fstk_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [3:0]  cmd_op;
  logic [15:0] cmd_data;
  logic [2:0]  rel_idx;
  logic [2:0]  phys_idx, top_ptr, slot_idx;
  logic [7:0]  tags;
  logic [15:0] status_word, control_word;
  logic        exc_pending, wait_fault;

  int n_total = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [2:0]  m_ptr, m_slot;
  logic [7:0]  m_tag;
  logic [15:0] m_stat, m_ctl;
  logic        m_fault;

  always #2.5 clk = ~clk;

  fstk_ctrl i_fstk_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .rel_idx(rel_idx), .phys_idx(phys_idx),
    .top_ptr(top_ptr), .tags(tags), .status_word(status_word),
    .control_word(control_word), .exc_pending(exc_pending),
    .slot_idx(slot_idx), .wait_fault(wait_fault)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_total++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word();
    logic [15:0] w;
    w = m_stat;
    w[13:11] = m_ptr;
    return w;
  endfunction

  task automatic check_all(input string req);
    chk(req, "top_ptr", int'(top_ptr), int'(m_ptr));
    chk(req, "tags", int'(tags), int'(m_tag));
    chk(req, "status_word", int'(status_word), int'(exp_word()));
    chk("R6", "ptr field", int'(status_word[13:11]), int'(m_ptr));
    chk(req, "control_word", int'(control_word), int'(m_ctl));
    chk(req, "slot_idx", int'(slot_idx), int'(m_slot));
    chk("R11", "wait_fault", int'(wait_fault), int'(m_fault));
    chk("R11", "exc_pending", int'(exc_pending), int'(m_stat[7]));
  endtask

  task automatic model_init();
    m_ptr = 3'd0; m_tag = 8'hFF; m_stat = 16'h0000; m_ctl = 16'h037F;
  endtask

  task automatic run(input logic [3:0] op, input logic [15:0] d, input string req);
    logic [2:0] ix;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    m_fault = 1'b0;
    case (op)
      4'd1: begin m_ptr = m_ptr - 3'd1; m_tag[m_ptr] = 1'b0; m_slot = m_ptr; end
      4'd2: begin m_tag[m_ptr] = 1'b1; m_slot = m_ptr; m_ptr = m_ptr + 3'd1; end
      4'd3: begin m_ptr = m_ptr + 3'd1; m_stat = m_stat & ~16'h4700; end
      4'd4: begin m_ptr = m_ptr - 3'd1; m_stat = m_stat & ~16'h4700; end
      4'd5: begin ix = m_ptr + d[2:0]; m_tag[ix] = 1'b1; end
      4'd6: model_init();
      4'd7: m_stat = m_stat & 16'h7F00;
      4'd8: begin
        m_stat = m_stat | {10'd0, d[5:0]};
        if ((m_stat[5:0] & ~m_ctl[5:0]) != 6'd0) m_stat = m_stat | 16'h8080;
      end
      4'd9: m_ctl = d;
      4'd10: m_fault = m_stat[7];
      4'd11: m_stat = (m_stat & ~16'h4700) | {1'b0, d[3], 3'b000, d[2:0], 8'h00};
      default: ;
    endcase
    @(posedge clk);
    #1;
    cmd_valid = 1'b0;
    check_all(req);
  endtask

  task automatic idle(input string req);
    @(negedge clk);
    m_fault = 1'b0;
    @(posedge clk);
    #1;
    check_all(req);
  endtask

  task automatic sweep_rel();
    for (int r = 0; r < 8; r++) begin
      rel_idx = 3'(r);
      #0.2;
      chk("R12", "phys_idx", int'(phys_idx), int'(3'(m_ptr + 3'(r))));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_total++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 4'd0; cmd_data = 16'd0; rel_idx = 3'd0;
    model_init(); m_slot = 3'd0; m_fault = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1 check_all("R1");

    // R2 / R12: push round the ring and past the wrap
    sweep_rel();
    for (int i = 0; i < 9; i++) begin
      run(4'd1, 16'd0, "R2");
      sweep_rel();
    end
    // R3: pop round the ring, including popping empty slots
    for (int i = 0; i < 10; i++) run(4'd2, 16'd0, "R3");

    // R4 with R11 condition-code load
    run(4'd1, 16'd0, "R2");
    run(4'd11, 16'h000F, "R11");
    run(4'd3, 16'd0, "R4");
    run(4'd11, 16'h000A, "R11");
    for (int i = 0; i < 9; i++) run(4'd4, 16'd0, "R4");
    run(4'd11, 16'h0005, "R11");
    for (int i = 0; i < 9; i++) run(4'd3, 16'd0, "R4");

    // R5: every offset from two pointers
    for (int p = 0; p < 2; p++) begin
      for (int i = 0; i < 8; i++) run(4'd1, 16'd0, "R2");
      for (int k = 0; k < 8; k++) begin
        run(4'd5, 16'(k) | 16'hFFF8, "R5");
        run(4'd1, 16'd0, "R2");
      end
      run(4'd3, 16'd0, "R4");
    end

    // R13: idle cycles and unused opcodes
    for (int i = 0; i < 3; i++) idle("R13");
    run(4'd0, 16'hFFFF, "R13");
    for (int op = 12; op < 16; op++) run(4'(op), 16'hFFFF, "R13");

    // R8: masked by the initial control word
    for (int f = 0; f < 6; f++) run(4'd8, 16'(1 << f), "R8");
    run(4'd10, 16'd0, "R11");
    run(4'd11, 16'h0009, "R11");
    run(4'd7, 16'd0, "R9");

    // R8/R10/R9/R11: every mask against every single flag
    for (int m = 0; m < 64; m++) begin
      for (int f = 0; f < 6; f++) begin
        run(4'd9, 16'h0340 | 16'(m), "R10");
        run(4'd8, 16'(1 << f), "R8");
        if (f == 0) run(4'd10, 16'd0, "R11");
        run(4'd11, 16'(f), "R11");
        run(4'd7, 16'd0, "R9");
      end
    end
    run(4'd10, 16'd0, "R11");

    // multi-flag raise with a partial mask, then wait twice
    run(4'd9, 16'h0337, "R10");
    run(4'd8, 16'h0013, "R8");
    run(4'd10, 16'd0, "R11");
    run(4'd10, 16'd0, "R11");
    idle("R11");

    // R7: initialise from a dirty state
    run(4'd1, 16'd0, "R2");
    run(4'd11, 16'h000F, "R11");
    run(4'd6, 16'd0, "R7");
    sweep_rel();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule